// File: doc/BRIEF.md
# Floating-Point Control Register File

This block holds the control state of a floating-point coprocessor. It has two registers behind a 5-bit control index. Index 0 selects a read-only identification word, and every other index selects a single control/status word. Software reads the words through a combinational read port and writes them through a synchronous write port. The control/status word keeps only the bits that are implemented. The other bits are dropped on every write, so they always read as zero.

The block drives two values to the rest of the unit. The first is the two-bit rounding mode taken from the low bits of the control/status word. The second is the condition flag held at bit 23, which a compare unit sets and clears with strobes and the branch logic tests. Every access is checked against a coprocessor-usable enable. An access made while that enable is low raises an exception request that carries coprocessor number 1. Such an access changes no state.

Top module: `fpu_ctl_regs`

## Requirements
- R1: After reset the control/status word is zero (rounding mode 0, condition flag 0), and index 0 reads the value of parameter ID_RESET.
- R2: With the enable high, a read of index 0 returns the identification word and a read of any nonzero index returns the control/status word. Both reads are combinational.
- R3: A write to index 0 changes nothing and raises no exception request.
- R4: A write to a nonzero index stores write data AND 0x0183FFFF, visible from the next cycle. Bits outside that mask always read as zero.
- R5: rnd_mode equals bits [1:0] of the control/status word: 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity.
- R6: The condition flag is bit 23 of the control/status word. br_true equals the flag and br_false equals its inverse.
- R7: A cmp_set strobe makes the flag 1 from the next cycle, and a cmp_clr strobe makes it 0. When both strobes arrive together, the set wins.
- R8: A write to a nonzero index in the same cycle as a compare strobe takes priority, so the flag takes bit 23 of the masked write data.
- R9: With the enable low, any of rd_req, wr_en, cmp_set, cmp_clr or br_req raises exc_req in the same cycle with exc_cop = 1. Writes and strobes then have no effect, and rd_data reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cu1_en | input | 1 | Coprocessor-usable enable |
| rd_req | input | 1 | Read access request |
| rd_idx | input | 5 | Read control index |
| rd_data | output | 32 | Read data |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 5 | Write control index |
| wr_data | input | 32 | Write data |
| cmp_set | input | 1 | Compare result true strobe |
| cmp_clr | input | 1 | Compare result false strobe |
| br_req | input | 1 | Branch query access |
| br_true | output | 1 | Branch-on-true answer |
| br_false | output | 1 | Branch-on-false answer |
| rnd_mode | output | 2 | Current rounding mode |
| fcc | output | 1 | Condition flag |
| exc_req | output | 1 | Coprocessor-unusable exception request |
| exc_cop | output | 2 | Coprocessor number of the exception |

## Verification
Directed writes of all-ones and of alternating patterns to a nonzero index show whether the mask is applied. A write of all-ones to index 0 shows whether the identification word is really read-only. The four rounding codes are written one after another, which separates a wrong bit selection from a wrong mode encoding. Write-against-strobe and set-against-clear collisions expose the priority order. Long random runs that toggle the enable show that gated accesses raise the exception and leave the state unchanged.

// File: rtl/fpu_ctl_regs.sv
module fpu_ctl_regs #(
  parameter int          IDX_W    = 5,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] ID_RESET = 32'h0000_0A30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cu1_en,
  input  logic              rd_req,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cmp_set,
  input  logic              cmp_clr,
  input  logic              br_req,
  output logic              br_true,
  output logic              br_false,
  output logic [1:0]        rnd_mode,
  output logic              fcc,
  output logic              exc_req,
  output logic [1:0]        exc_cop
);
  localparam logic [DATA_W-1:0] IMPL_MASK = DATA_W'(32'h0183_FFFF);
  localparam int                FCC_BIT   = 23;

  logic [DATA_W-1:0] csr_q;
  logic              sw_wr;
  logic              any_acc;

  assign any_acc = rd_req | wr_en | cmp_set | cmp_clr | br_req;
  assign sw_wr   = cu1_en & wr_en & (wr_idx != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)
      csr_q <= '0;
    else if (sw_wr)
      csr_q <= wr_data & IMPL_MASK;
    else if (cu1_en & cmp_set)
      csr_q[FCC_BIT] <= 1'b1;
    else if (cu1_en & cmp_clr)
      csr_q[FCC_BIT] <= 1'b0;
  end

  assign rd_data  = !cu1_en ? '0 : (rd_idx == '0) ? DATA_W'(ID_RESET) : csr_q;
  assign rnd_mode = csr_q[1:0];
  assign fcc      = csr_q[FCC_BIT];
  assign br_true  = fcc;
  assign br_false = ~fcc;
  assign exc_req  = any_acc & ~cu1_en;
  assign exc_cop  = 2'd1;
endmodule

// File: rtl/fpu_ctl_regs_chk.sv
module fpu_ctl_regs_chk #(
  parameter int          IDX_W    = 5,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] ID_RESET = 32'h0000_0A30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cu1_en,
  input logic              rd_req,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [DATA_W-1:0] rd_data,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              cmp_set,
  input logic              cmp_clr,
  input logic              br_req,
  input logic              br_true,
  input logic              br_false,
  input logic [1:0]        rnd_mode,
  input logic              fcc,
  input logic              exc_req,
  input logic [1:0]        exc_cop
);
  localparam logic [DATA_W-1:0] MSK = DATA_W'(32'h0183_FFFF);

  p_id_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cu1_en && rd_idx == '0) |-> rd_data == DATA_W'(ID_RESET));

  p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cu1_en && rd_idx != '0) |-> (rd_data & ~MSK) == '0);

  p_rnd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cu1_en && wr_en && wr_idx != '0) |=> rnd_mode == $past(wr_data[1:0]));

  p_wrprio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cu1_en && wr_en && wr_idx != '0) |=> (fcc == $past(wr_data[23])) && (br_true == $past(wr_data[23])) && (br_false != $past(wr_data[23])));

  p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cu1_en && cmp_set && !(wr_en && wr_idx != '0)) |=> fcc);

  p_exc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cu1_en && (rd_req || wr_en || cmp_set || cmp_clr || br_req)) |-> (exc_req && exc_cop == 2'd1));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cu1_en |=> ($stable(fcc) && $stable(rnd_mode)));

  p_noexc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cu1_en |-> !exc_req);
endmodule

bind fpu_ctl_regs fpu_ctl_regs_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W), .ID_RESET(ID_RESET)) u_chk (.*);

// File: tb/sim_fpu_ctl_regs.sv
`timescale 1ns/1ps
module sim_fpu_ctl_regs;
  localparam logic [31:0] ID  = 32'h0000_0A30;
  localparam logic [31:0] MSK = 32'h0183_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cu1_en = 1'b0, rd_req = 1'b0, wr_en = 1'b0, cmp_set = 1'b0, cmp_clr = 1'b0, br_req = 1'b0;
  logic [4:0] rd_idx = '0, wr_idx = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic br_true, br_false, fcc, exc_req;
  logic [1:0] rnd_mode, exc_cop;

  int checks = 0, failures = 0;
  logic [31:0] m = '0;
  bit done = 0;

  always #2 clk = ~clk;

  fpu_ctl_regs u0 (.*);

  function automatic logic [31:0] exp_rd(logic en, logic [4:0] idx, logic [31:0] st);
    if (!en) return 32'h0;
    return (idx == 0) ? ID : st;
  endfunction

  function automatic logic [31:0] next_st(logic [31:0] st, logic en, logic we, logic [4:0] wi,
                                          logic [31:0] wd, logic cs, logic cc);
    logic [31:0] n = st;
    if (en && we && wi != 0) n = wd & MSK;
    else if (en && cs) n[23] = 1'b1;
    else if (en && cc) n[23] = 1'b0;
    return n;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic verify_all(string tag);
    logic ex = !cu1_en && (rd_req || wr_en || cmp_set || cmp_clr || br_req);
    chk({tag, " R2 rd_data"}, rd_data, exp_rd(cu1_en, rd_idx, m));
    chk({tag, " R5 rnd_mode"}, 32'(rnd_mode), 32'(m[1:0]));
    chk({tag, " R6 fcc/br"}, {29'd0, fcc, br_true, br_false}, {29'd0, m[23], m[23], ~m[23]});
    chk({tag, " R9 exc"}, {29'd0, exc_req, exc_cop}, {29'd0, ex, 2'd1});
  endtask

  task automatic cyc(string tag, logic en, logic rr, logic [4:0] ri, logic we, logic [4:0] wi,
                     logic [31:0] wd, logic cs, logic cc, logic br);
    @(negedge clk);
    cu1_en = en; rd_req = rr; rd_idx = ri; wr_en = we; wr_idx = wi; wr_data = wd;
    cmp_set = cs; cmp_clr = cc; br_req = br;
    #1 verify_all(tag);
    @(posedge clk);
    m = next_st(m, en, we, wi, wd, cs, cc);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    cu1_en = 1'b1;
    #1;
    chk("R1 reset id", rd_data, ID);
    rd_idx = 5'd31; #1;
    chk("R1 reset csr", rd_data, 32'h0);
    chk("R1 reset fcc/mode", {29'd0, fcc, rnd_mode}, 32'h0);
    cyc("R3 write idx0", 1, 1, 0, 1, 0, 32'hFFFF_FFFF, 0, 0, 0);
    cyc("R3 after idx0", 1, 1, 5, 0, 0, 0, 0, 0, 0);
    cyc("R4 all ones", 1, 0, 0, 1, 31, 32'hFFFF_FFFF, 0, 0, 0);
    cyc("R4 readback", 1, 1, 31, 0, 0, 0, 0, 0, 0);
    chk("R4 masked value", rd_data, MSK);
    cyc("R4 alt", 1, 1, 1, 1, 1, 32'hAAAA_5555, 0, 0, 0);
    cyc("R4 alt rb", 1, 1, 1, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) begin
      cyc("R5 mode wr", 1, 0, 0, 1, 2, 32'(k), 0, 0, 0);
      cyc("R5 mode rb", 1, 1, 2, 0, 0, 0, 0, 0, 1);
      chk("R5 mode value", 32'(rnd_mode), 32'(k));
    end
    cyc("R7 set", 1, 0, 0, 0, 0, 0, 1, 0, 1);
    cyc("R7 seen", 1, 0, 0, 0, 0, 0, 0, 1, 1);
    cyc("R7 clr seen", 1, 0, 0, 0, 0, 0, 1, 1, 1);
    cyc("R7 both set wins", 1, 0, 0, 0, 0, 0, 0, 0, 1);
    cyc("R8 write vs set", 1, 0, 0, 1, 3, 32'h0, 1, 0, 0);
    cyc("R8 result", 1, 1, 3, 0, 0, 0, 0, 0, 1);
    chk("R8 fcc zero", 32'(fcc), 32'd0);
    cyc("R8 write vs clr", 1, 0, 0, 1, 3, 32'h0080_0000, 0, 1, 0);
    cyc("R8 result2", 1, 1, 3, 0, 0, 0, 0, 0, 1);
    chk("R8 fcc one", 32'(fcc), 32'd1);
    cyc("R9 gated write", 0, 1, 3, 1, 3, 32'h0000_0003, 0, 1, 1);
    cyc("R9 gated after", 1, 1, 3, 0, 0, 0, 0, 0, 0);
    chk("R9 state kept", rd_data, 32'h0080_0000);
    cyc("R9 idle gated", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      logic en = ($urandom % 5) != 0;
      cyc("rand", en, 1'($urandom), 5'($urandom % 4 == 0 ? 0 : $urandom), 1'($urandom % 3 == 0),
          5'($urandom % 4 == 0 ? 0 : $urandom), $urandom, 1'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule